// File: doc/BRIEF.md
# Bearing Test Station Sequencer

This block is the clocked sequencer for a carriage station that checks whether a gear wheel has a bearing pressed into its bore. The station starts from the home position when the upstream station requests a transfer. It drives the carriage to the right past a part sensor. If no part was seen, it sends the carriage straight back and asks for a new part. If a part was seen, it stops at the probe position, lets the carriage settle, and extends a probe cylinder into the bore. It latches the cylinder switch as the bearing result, then retracts the cylinder. After that it carries the part on to the hand-off position, waits for the gripper to take it, and returns home.

Two safety rules are part of the sequencer itself. First, the probe cylinder can only be extended while the probe-position switch is closed. Second, a probe that does not start within a fixed number of cycles after the carriage stops sends the block into a fault state. The fault state stops all motion and is left only through reset. Settle time, probe deadline and probe/retract dwell are parameters.

Top module: `brg_test_seq`

## Requirements
- R1: After reset, motorRight, motorLeft, cylExtend, newPartReq, resultValid and faultErr are 0, and cylRetract is 1.
- R2: When idle, a cycle starts only if xferReq and homePos are both 1 at a clock edge; motorRight is then 1 from that edge on. xferReq while homePos is 0 has no effect.
- R3: If testPos closes while moving right and partSense was never 1 during that run, the carriage drives motorLeft with newPartReq=1 until homePos is 1, and then goes idle.
- R4: If a part was seen, the carriage stops (both motors 0) on the edge where testPos closes. cylExtend follows after testPos has been 1 for SETTLE_CYC consecutive stopped cycles. A 0 on testPos restarts that count.
- R5: cylExtend is never 1 while testPos is 0. If testPos opens during the probe, cylExtend drops in the same cycle and faultErr is 1 from the next edge.
- R6: The probe lasts PROBE_CYC cycles. On its last edge, bearingSw is stored on bearingOk and resultValid becomes 1. Both are cleared when the next cycle starts.
- R7: After the probe, cylRetract is 1 with both motors 0 for PROBE_CYC cycles. The carriage then moves right until xferPos is 1, stops until pickDone is 1, and moves left until homePos is 1.
- R8: If the carriage stays stopped at the probe position for DEADLINE cycles without the settle condition being met, faultErr is 1 from the next edge.
- R9: In the fault state, faultErr stays 1 and motorRight, motorLeft, cylExtend and cylRetract are all 0 whatever the inputs. Only reset leaves the fault state.
- R10: motorRight and motorLeft are never both 1, and cylExtend and cylRetract are never both 1.
- R11: Once a part has been detected, motorLeft stays 0 until pickDone reports the part removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferReq | input | 1 | Upstream station offers a part |
| homePos | input | 1 | Carriage at receiving position |
| partSense | input | 1 | Part sensor on the carriage path |
| testPos | input | 1 | Carriage at probe position |
| bearingSw | input | 1 | Cylinder switch: 1 = bearing present |
| xferPos | input | 1 | Carriage at hand-off position |
| pickDone | input | 1 | Gripper has removed the part |
| motorRight | output | 1 | Drive carriage right |
| motorLeft | output | 1 | Drive carriage left |
| cylExtend | output | 1 | Extend probe cylinder |
| cylRetract | output | 1 | Retract probe cylinder |
| newPartReq | output | 1 | Request a new part (empty return) |
| bearingOk | output | 1 | Latched bearing result |
| resultValid | output | 1 | bearingOk holds a result of this cycle |
| faultErr | output | 1 | Sticky fault flag |

## Verification
The bench drives a bouncing probe switch during settle. A design that keeps counting instead of restarting would probe too early, and one that restarts the deadline on each bounce would never raise the fault. It also lets the switch chatter until the deadline expires and checks the exact cycle of the fault. It opens testPos in the middle of a probe, where a design that gates cylExtend only by state would keep extending off position. It runs an empty pass, where a design that ignores the part flag would park at the probe position instead of returning. It then drives inputs in the fault state to show that a non-sticky fault would start moving again.

// File: rtl/brg_seq_pkg.sv
package brg_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RUN,
    ST_EMPTY_BACK,
    ST_SETTLE,
    ST_PROBE,
    ST_RETRACT,
    ST_TO_XFER,
    ST_WAIT_PICK,
    ST_HOME_BACK,
    ST_FAULT
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrStep;    // state changes on this edge
    logic inSettle;   // carriage stopped, waiting to probe
    logic trackPart;  // watch the part sensor
    logic clrPart;    // forget the part flag
    logic takeSample; // store the cylinder switch
    logic clrResult;  // drop the previous result
  } dpStrobe_t;

endpackage

// File: rtl/brg_seq_dp.sv
module brg_seq_dp
  import brg_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int DEADLINE   = 10,
  parameter int PROBE_CYC  = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  input  logic      testPos,
  input  logic      partSense,
  input  logic      bearingSw,
  output logic      settleDone,
  output logic      deadlineHit,
  output logic      phaseDone,
  output logic      partSeen,
  output logic      bearingOk,
  output logic      resultValid
);

  localparam int STEP_MAX = (DEADLINE > PROBE_CYC) ? DEADLINE : PROBE_CYC;
  localparam int STEP_W   = $clog2(STEP_MAX + 1);
  localparam int HOLD_W   = $clog2(SETTLE_CYC + 1);

  logic [STEP_W-1:0] stepCnt;
  logic [HOLD_W-1:0] holdCnt;

  // cycles spent in the current state, saturating
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrStep) stepCnt <= '0;
    else if (stepCnt != STEP_W'(STEP_MAX)) stepCnt <= stepCnt + 1'b1;
  end

  // consecutive stopped cycles with the probe switch closed
  always_ff @(posedge clk) begin
    if (!rstN || !strobe.inSettle || !testPos) holdCnt <= '0;
    else if (holdCnt != HOLD_W'(SETTLE_CYC)) holdCnt <= holdCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrPart) partSeen <= 1'b0;
    else if (strobe.trackPart && partSense) partSeen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrResult) begin
      bearingOk   <= 1'b0;
      resultValid <= 1'b0;
    end else if (strobe.takeSample) begin
      bearingOk   <= bearingSw;
      resultValid <= 1'b1;
    end
  end

  assign settleDone  = testPos && (holdCnt == HOLD_W'(SETTLE_CYC - 1));
  assign deadlineHit = (stepCnt == STEP_W'(DEADLINE - 1));
  assign phaseDone   = (stepCnt == STEP_W'(PROBE_CYC - 1));

endmodule

// File: rtl/brg_seq_ctrl.sv
module brg_seq_ctrl
  import brg_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      xferReq,
  input  logic      homePos,
  input  logic      partSense,
  input  logic      testPos,
  input  logic      xferPos,
  input  logic      pickDone,
  input  logic      settleDone,
  input  logic      deadlineHit,
  input  logic      phaseDone,
  input  logic      partSeen,
  output dpStrobe_t strobe,
  output logic      motorRight,
  output logic      motorLeft,
  output logic      cylExtend,
  output logic      cylRetract,
  output logic      newPartReq,
  output logic      faultErr
);

  seqState_t state, nxt;
  logic      goStart;

  assign goStart = (state == ST_IDLE) && xferReq && homePos;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:       if (goStart) nxt = ST_RUN;
      ST_RUN:        if (testPos) nxt = (partSeen || partSense) ? ST_SETTLE : ST_EMPTY_BACK;
      ST_EMPTY_BACK: if (homePos) nxt = ST_IDLE;
      ST_SETTLE: begin
        if (settleDone)       nxt = ST_PROBE;
        else if (deadlineHit) nxt = ST_FAULT;
      end
      ST_PROBE: begin
        if (!testPos)       nxt = ST_FAULT;
        else if (phaseDone) nxt = ST_RETRACT;
      end
      ST_RETRACT:    if (phaseDone) nxt = ST_TO_XFER;
      ST_TO_XFER:    if (xferPos)   nxt = ST_WAIT_PICK;
      ST_WAIT_PICK:  if (pickDone)  nxt = ST_HOME_BACK;
      ST_HOME_BACK:  if (homePos)   nxt = ST_IDLE;
      default:                      nxt = ST_FAULT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    strobe            = '0;
    strobe.clrStep    = (nxt != state);
    strobe.inSettle   = (state == ST_SETTLE);
    strobe.trackPart  = (state == ST_RUN);
    strobe.clrPart    = goStart;
    strobe.clrResult  = goStart;
    strobe.takeSample = (state == ST_PROBE) && testPos && phaseDone;
  end

  assign motorRight = (state == ST_RUN) || (state == ST_TO_XFER);
  assign motorLeft  = (state == ST_EMPTY_BACK) || (state == ST_HOME_BACK);
  assign cylExtend  = (state == ST_PROBE) && testPos;
  assign cylRetract = (state != ST_PROBE) && (state != ST_FAULT);
  assign newPartReq = (state == ST_EMPTY_BACK);
  assign faultErr   = (state == ST_FAULT);

endmodule

// File: rtl/brg_test_seq.sv
module brg_test_seq
  import brg_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int DEADLINE   = 10,
  parameter int PROBE_CYC  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic xferReq,
  input  logic homePos,
  input  logic partSense,
  input  logic testPos,
  input  logic bearingSw,
  input  logic xferPos,
  input  logic pickDone,
  output logic motorRight,
  output logic motorLeft,
  output logic cylExtend,
  output logic cylRetract,
  output logic newPartReq,
  output logic bearingOk,
  output logic resultValid,
  output logic faultErr
);

  dpStrobe_t strobe;
  logic      settleDone, deadlineHit, phaseDone, partSeen;

  brg_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .xferReq(xferReq), .homePos(homePos),
    .partSense(partSense), .testPos(testPos), .xferPos(xferPos),
    .pickDone(pickDone), .settleDone(settleDone), .deadlineHit(deadlineHit),
    .phaseDone(phaseDone), .partSeen(partSeen), .strobe(strobe),
    .motorRight(motorRight), .motorLeft(motorLeft), .cylExtend(cylExtend),
    .cylRetract(cylRetract), .newPartReq(newPartReq), .faultErr(faultErr)
  );

  brg_seq_dp #(
    .SETTLE_CYC(SETTLE_CYC), .DEADLINE(DEADLINE), .PROBE_CYC(PROBE_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .testPos(testPos),
    .partSense(partSense), .bearingSw(bearingSw), .settleDone(settleDone),
    .deadlineHit(deadlineHit), .phaseDone(phaseDone), .partSeen(partSeen),
    .bearingOk(bearingOk), .resultValid(resultValid)
  );

endmodule

// File: rtl/brg_test_seq_chk.sv
module brg_test_seq_chk (
  input logic clk,
  input logic rstN,
  input logic partSense,
  input logic pickDone,
  input logic testPos,
  input logic motorRight,
  input logic motorLeft,
  input logic cylExtend,
  input logic cylRetract,
  input logic resultValid,
  input logic faultErr
);

  // part on the carriage as seen from the ports
  logic partLoaded;
  always_ff @(posedge clk) begin
    if (!rstN || pickDone)           partLoaded <= 1'b0;
    else if (motorRight && partSense) partLoaded <= 1'b1;
  end

  AST_EXT_ON_POSITION: assert property (@(posedge clk) disable iff (!rstN) cylExtend |-> testPos); // R5
  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) !(motorRight && motorLeft)); // R10
  AST_CYL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) !(cylExtend && cylRetract)); // R10
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN) faultErr |=> faultErr); // R9
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    faultErr |-> !(motorRight || motorLeft || cylExtend || cylRetract)); // R9
  AST_RESULT_FROM_PROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resultValid) |-> $past(cylExtend)); // R6
  AST_STILL_WHILE_PROBING: assert property (@(posedge clk) disable iff (!rstN)
    cylExtend |-> !(motorRight || motorLeft)); // R7
  AST_STILL_AFTER_PROBE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(cylExtend) && !faultErr) |-> !(motorRight || motorLeft)); // R7
  AST_NO_LEFT_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    partLoaded |-> !motorLeft); // R11

endmodule

bind brg_test_seq brg_test_seq_chk chk_i (
  .clk(clk), .rstN(rstN), .partSense(partSense), .pickDone(pickDone),
  .testPos(testPos), .motorRight(motorRight), .motorLeft(motorLeft),
  .cylExtend(cylExtend), .cylRetract(cylRetract), .resultValid(resultValid),
  .faultErr(faultErr)
);

// File: tb/brg_test_seq_tb_top.sv
module brg_test_seq_tb_top;

  localparam int SETTLE_CYC = 4;
  localparam int DEADLINE   = 10;
  localparam int PROBE_CYC  = 3;

  logic clk = 1'b0;
  logic rstN;
  logic xferReq, homePos, partSense, testPos, bearingSw, xferPos, pickDone;
  logic motorRight, motorLeft, cylExtend, cylRetract, newPartReq, bearingOk, resultValid, faultErr;

  always #5 clk = ~clk;

  brg_test_seq #(.SETTLE_CYC(SETTLE_CYC), .DEADLINE(DEADLINE), .PROBE_CYC(PROBE_CYC)) dut_i (
    .clk(clk), .rstN(rstN), .xferReq(xferReq), .homePos(homePos), .partSense(partSense),
    .testPos(testPos), .bearingSw(bearingSw), .xferPos(xferPos), .pickDone(pickDone),
    .motorRight(motorRight), .motorLeft(motorLeft), .cylExtend(cylExtend),
    .cylRetract(cylRetract), .newPartReq(newPartReq), .bearingOk(bearingOk),
    .resultValid(resultValid), .faultErr(faultErr)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic expect1(string tag, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  // phases: 0 idle, 1 right, 2 empty back, 3 stopped, 4 probing,
  // 5 retracting, 6 to hand-off, 7 waiting pick, 8 home back, 9 fault
  int  ph = 0, tIn = 0, closedRun = 0;
  bit  seen = 0, mOk = 0, mValid = 0, live = 0;

  function automatic void enter(int p);
    ph = p; tIn = 0; closedRun = 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      enter(0); seen = 0; mOk = 0; mValid = 0; live = 1;
    end else begin
      case (ph)
        0: if (xferReq && homePos) begin seen = 0; mOk = 0; mValid = 0; enter(1); end
        1: begin
          if (partSense) seen = 1;
          if (testPos) enter(seen ? 3 : 2);
        end
        2, 8: if (homePos) enter(0);
        3: begin
          if (testPos && closedRun == SETTLE_CYC - 1) enter(4);
          else if (tIn == DEADLINE - 1) enter(9);
          else begin closedRun = testPos ? closedRun + 1 : 0; tIn++; end
        end
        4: begin
          if (!testPos) enter(9);
          else if (tIn == PROBE_CYC - 1) begin mOk = bearingSw; mValid = 1; enter(5); end
          else tIn++;
        end
        5: if (tIn == PROBE_CYC - 1) enter(6); else tIn++;
        6: if (xferPos) enter(7);
        7: if (pickDone) enter(8);
        default: ;
      endcase
    end
  end

  // compare every output on every cycle, away from the active edge
  always @(negedge clk) begin
    if (live && rstN && !finished) begin
      expect1("R7",  "motorRight", motorRight, ph == 1 || ph == 6);
      expect1("R3",  "motorLeft",  motorLeft,  ph == 2 || ph == 8);
      expect1("R5",  "cylExtend",  cylExtend,  ph == 4 && testPos);
      expect1("R10", "cylRetract", cylRetract, ph != 4 && ph != 9);
      expect1("R3",  "newPartReq", newPartReq, ph == 2);
      expect1("R6",  "bearingOk",  bearingOk,  mOk);
      expect1("R6",  "resultValid", resultValid, mValid);
      expect1("R9",  "faultErr",   faultErr,   ph == 9);
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic startCycle();
    homePos = 1; xferReq = 1; step(1);
    #1 expect1("R2", "motorRight after start", motorRight, 1'b1);
    xferReq = 0; homePos = 0;
  endtask

  // run to the probe position with a part; returns right after the stop edge
  task automatic runToStop();
    startCycle();
    step(1); partSense = 1; step(1); partSense = 0; step(2);
    testPos = 1; step(1);
    #1 expect1("R4", "motorRight at stop", motorRight, 1'b0);
    expect1("R11", "motorLeft at stop", motorLeft, 1'b0);
  endtask

  task automatic fullPart(bit bounce, bit bearing);
    runToStop();
    expect1("R6", "resultValid cleared at start", resultValid, 1'b0);
    if (bounce) begin
      step(1); testPos = 0; step(1); testPos = 1;
      #1 expect1("R4", "no probe after bounce", cylExtend, 1'b0);
    end
    bearingSw = bearing;
    for (int i = 0; i < 20 && !cylExtend; i++) step(1);
    #1 expect1("R4", "probe extended", cylExtend, 1'b1);
    for (int i = 0; i < 20 && !resultValid; i++) step(1);
    #1 expect1("R6", "bearing result", bearingOk, bearing);
    expect1("R7", "still during retract", motorRight, 1'b0);
    expect1("R7", "retracting", cylRetract, 1'b1);
    for (int i = 0; i < 20 && !motorRight; i++) step(1);
    #1 expect1("R7", "moving to hand-off", motorRight, 1'b1);
    expect1("R10", "one direction", motorLeft, 1'b0);
    testPos = 0; bearingSw = 0; step(3);
    xferPos = 1; step(1);
    #1 expect1("R7", "stopped at hand-off", motorRight, 1'b0);
    step(3);
    #1 expect1("R11", "no left before pick", motorLeft, 1'b0);
    pickDone = 1; step(1); pickDone = 0; xferPos = 0;
    #1 expect1("R7", "return home", motorLeft, 1'b1);
    step(3); homePos = 1; step(1);
    #1 expect1("R7", "home and idle", motorLeft, 1'b0);
  endtask

  task automatic doReset();
    rstN = 0; step(2); rstN = 1; step(1);
  endtask

  initial begin
    rstN = 0; xferReq = 0; homePos = 1; partSense = 0; testPos = 0;
    bearingSw = 0; xferPos = 0; pickDone = 0;
    step(3); rstN = 1; step(1);
    #1;
    expect1("R1", "motorRight", motorRight, 1'b0);
    expect1("R1", "motorLeft",  motorLeft,  1'b0);
    expect1("R1", "cylExtend",  cylExtend,  1'b0);
    expect1("R1", "cylRetract", cylRetract, 1'b1);
    expect1("R1", "newPartReq", newPartReq, 1'b0);
    expect1("R1", "resultValid", resultValid, 1'b0);
    expect1("R1", "faultErr",   faultErr,   1'b0);

    // start request away from home is ignored
    homePos = 0; xferReq = 1; step(3);
    #1 expect1("R2", "ignored start", motorRight, 1'b0);
    xferReq = 0;

    // empty pass
    startCycle();
    step(3); testPos = 1; step(1);
    #1 expect1("R3", "empty return left", motorLeft, 1'b1);
    expect1("R3", "new part request", newPartReq, 1'b1);
    expect1("R10", "not both directions", motorRight, 1'b0);
    testPos = 0; step(4); homePos = 1; step(1);
    #1 expect1("R3", "empty return ends", newPartReq, 1'b0);

    // good parts
    fullPart(1'b1, 1'b1);
    fullPart(1'b0, 1'b0);

    // probe switch opens mid-probe
    runToStop();
    for (int i = 0; i < 20 && !cylExtend; i++) step(1);
    testPos = 0;
    #1 expect1("R5", "extend drops off position", cylExtend, 1'b0);
    step(1);
    #1 expect1("R5", "fault after opening", faultErr, 1'b1);
    xferReq = 1; homePos = 1; testPos = 1; pickDone = 1; step(4);
    #1 expect1("R9", "fault sticky", faultErr, 1'b1);
    expect1("R9", "no motion in fault", motorRight | motorLeft | cylExtend | cylRetract, 1'b0);
    xferReq = 0; pickDone = 0; testPos = 0;
    doReset();
    #1 expect1("R9", "reset clears fault", faultErr, 1'b0);

    // chattering switch: deadline expires
    runToStop();
    begin
      int n = 0;
      for (int i = 0; i < 3 * DEADLINE && !faultErr; i++) begin
        testPos = (i % 3 != 2);
        step(1);
        n++;
      end
      #1 expect1("R8", "deadline fault", faultErr, 1'b1);
      checks++;
      if (n != DEADLINE) begin
        fails++;
        $display("FAIL R8 fault cycle: actual %0d expected %0d", n, DEADLINE);
      end
    end
    testPos = 0;
    doReset();
    #1 expect1("R1", "clean after reset", faultErr, 1'b0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule